// File: doc/BRIEF.md
# Clamped Proportional-Integral Regulator

This block is a clocked proportional-integral controller for a feedback loop. Each time a signed error sample arrives with its strobe, it adds the sample to a running integrator and weighs both the new integrator value and the sample by programmable gains. The gains are fixed-point numbers with 12 fractional bits. The weighted sum is scaled down, a programmable offset is added, and the result is forced into a programmable window before it is presented as the actuator word. The output strobe follows one clock later.

When the result hits either limit and the anti-windup enable is set, the integrator keeps its old value unless the new value would pull the output back toward the window. A clear input zeroes the integrator without touching the gains, the offset or the limits. The integrator, the last actuator word and the last error sample are visible on ports, so a supervising sequencer can inspect the loop or hand its state to a later stage.

Top module: `pi_regulator`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_word, rb_integ and rb_last_x all become zero.
- R2: out_valid is high in exactly the cycle after each cycle in which smp_valid was high, and low otherwise.
- R3: For a sample x, the candidate integrator is c = I + x, where I is the old integrator. The unclamped result is u = floor((c*ki + x*kp) / 4096) + bias, with the division implemented as an arithmetic right shift by 12. All terms are signed two's complement.
- R4: If u < y_min, out_word becomes y_min.
- R5: If u > y_max, out_word becomes y_max. When neither limit is crossed, out_word becomes u.
- R6: When anti-windup is off, or when u lies within [y_min, y_max], the integrator takes c.
- R7: With anti-windup on and u < y_min, the integrator takes c only if c > I, and otherwise keeps I.
- R8: With anti-windup on and u > y_max, the integrator takes c only if c < I, and otherwise keeps I.
- R9: integ_clr without smp_valid sets rb_integ to zero on the next edge. out_word, rb_last_x, the gains, the bias and the limits keep their effect.
- R10: When integ_clr and smp_valid are high in the same cycle, the sample is processed with I taken as zero.
- R11: Between samples, out_word and rb_last_x hold their values. rb_last_x equals the most recent accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Error sample strobe |
| smp_err | input | X_W | Signed error sample |
| cfg_kp | input | K_W | Proportional gain, 12 fractional bits |
| cfg_ki | input | K_W | Integral gain, 12 fractional bits |
| cfg_bias | input | Y_W | Signed offset added after scaling |
| cfg_y_min | input | Y_W | Lower output limit |
| cfg_y_max | input | Y_W | Upper output limit |
| cfg_awu_en | input | 1 | Anti-windup enable |
| integ_clr | input | 1 | Zero the integrator |
| out_valid | output | 1 | Actuator word updated last edge |
| out_word | output | Y_W | Clamped actuator word |
| rb_integ | output | I_W | Current integrator |
| rb_last_x | output | X_W | Last accepted error sample |

## Verification
A clear and a sample can arrive in the same cycle. The bench first builds a non-zero integrator, then raises integ_clr together with smp_valid. It then checks that the output and the integrator equal those of a lone sample applied to a zero integrator.

The other collision is between a limit being hit and the integrator update decision. The bench drives the anti-windup case into each limit twice: once with a sample that points away from the window, where the integrator must freeze, and once with a sample that points back, where it must move.

// File: rtl/pi_reg_pkg.sv
// Package: shared types and defaults for the PI regulator.
// Assumes: nothing; pure declarations.
package pi_reg_pkg;
    typedef enum logic [1:0] {
        LIM_NONE = 2'd0,
        LIM_LOW  = 2'd1,
        LIM_HIGH = 2'd2
    } lim_e;

    localparam int DEF_FRAC = 12;
endpackage

// File: rtl/pi_mac.sv
// Module: pi_mac
// Forms the candidate integrator and the unclamped, scaled, biased output.
// Assumes: I_W > X_W, S_W >= I_W + K_W + 1 so no product or sum overflows.
module pi_mac #(
    parameter int X_W  = 16,
    parameter int I_W  = 32,
    parameter int K_W  = 16,
    parameter int Y_W  = 16,
    parameter int FRAC = 12,
    parameter int S_W  = 49
) (
    input  logic signed [I_W-1:0] base_i,
    input  logic signed [X_W-1:0] x_i,
    input  logic signed [K_W-1:0] kp_i,
    input  logic signed [K_W-1:0] ki_i,
    input  logic signed [Y_W-1:0] bias_i,
    output logic signed [I_W-1:0] cand_o,
    output logic signed [S_W-1:0] raw_o
);
    logic signed [I_W-1:0] x_ext;
    logic signed [S_W-1:0] cand_s, x_s, kp_s, ki_s, bias_s, acc, shifted;

    // Sign-extend every operand to the working width and combine.
    always_comb begin
        x_ext   = {{(I_W-X_W){x_i[X_W-1]}}, x_i};
        cand_o  = base_i + x_ext;
        cand_s  = {{(S_W-I_W){cand_o[I_W-1]}}, cand_o};
        x_s     = {{(S_W-X_W){x_i[X_W-1]}}, x_i};
        kp_s    = {{(S_W-K_W){kp_i[K_W-1]}}, kp_i};
        ki_s    = {{(S_W-K_W){ki_i[K_W-1]}}, ki_i};
        bias_s  = {{(S_W-Y_W){bias_i[Y_W-1]}}, bias_i};
        acc     = cand_s * ki_s + x_s * kp_s;
        shifted = acc >>> FRAC;
        raw_o   = shifted + bias_s;
    end
endmodule

// File: rtl/pi_clamp.sv
// Module: pi_clamp
// Forces the raw result into [y_min, y_max] and decides whether the
// integrator may take the candidate (anti-windup rule).
// Assumes: y_min <= y_max; the raw value is wider than the output.
module pi_clamp
    import pi_reg_pkg::*;
#(
    parameter int I_W = 32,
    parameter int Y_W = 16,
    parameter int S_W = 49
) (
    input  logic signed [S_W-1:0] raw_i,
    input  logic signed [Y_W-1:0] y_min_i,
    input  logic signed [Y_W-1:0] y_max_i,
    input  logic                  awu_i,
    input  logic signed [I_W-1:0] cand_i,
    input  logic signed [I_W-1:0] base_i,
    output logic signed [Y_W-1:0] y_o,
    output logic                  accept_o
);
    logic signed [S_W-1:0] lo_s, hi_s;
    lim_e lim;

    // Classify the raw value against the window.
    always_comb begin
        lo_s = {{(S_W-Y_W){y_min_i[Y_W-1]}}, y_min_i};
        hi_s = {{(S_W-Y_W){y_max_i[Y_W-1]}}, y_max_i};
        if (raw_i < lo_s)      lim = LIM_LOW;
        else if (raw_i > hi_s) lim = LIM_HIGH;
        else                   lim = LIM_NONE;
    end

    // Pick the output word and the integrator acceptance.
    always_comb begin
        case (lim)
            LIM_LOW: begin
                y_o      = y_min_i;
                accept_o = !awu_i || (cand_i > base_i);
            end
            LIM_HIGH: begin
                y_o      = y_max_i;
                accept_o = !awu_i || (cand_i < base_i);
            end
            default: begin
                y_o      = raw_i[Y_W-1:0];
                accept_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pi_regulator.sv
// Module: pi_regulator (top)
// One PI update per smp_valid; registered output one cycle later.
// Assumes: cfg_y_min <= cfg_y_max; gains carry FRAC fractional bits.
module pi_regulator #(
    parameter int X_W  = 16,
    parameter int I_W  = 32,
    parameter int K_W  = 16,
    parameter int Y_W  = 16,
    parameter int FRAC = pi_reg_pkg::DEF_FRAC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic signed [X_W-1:0] smp_err,
    input  logic signed [K_W-1:0] cfg_kp,
    input  logic signed [K_W-1:0] cfg_ki,
    input  logic signed [Y_W-1:0] cfg_bias,
    input  logic signed [Y_W-1:0] cfg_y_min,
    input  logic signed [Y_W-1:0] cfg_y_max,
    input  logic                  cfg_awu_en,
    input  logic                  integ_clr,
    output logic                  out_valid,
    output logic signed [Y_W-1:0] out_word,
    output logic signed [I_W-1:0] rb_integ,
    output logic signed [X_W-1:0] rb_last_x
);
    localparam int S_W = I_W + K_W + 1;

    logic signed [I_W-1:0] base, cand;
    logic signed [S_W-1:0] raw;
    logic signed [Y_W-1:0] y_next;
    logic                  accept;

    // Clear in the same cycle as a sample restarts from zero.
    always_comb base = integ_clr ? '0 : rb_integ;

    pi_mac #(.X_W(X_W), .I_W(I_W), .K_W(K_W), .Y_W(Y_W), .FRAC(FRAC), .S_W(S_W)) u_mac (
        .base_i(base), .x_i(smp_err), .kp_i(cfg_kp), .ki_i(cfg_ki),
        .bias_i(cfg_bias), .cand_o(cand), .raw_o(raw)
    );

    pi_clamp #(.I_W(I_W), .Y_W(Y_W), .S_W(S_W)) u_clamp (
        .raw_i(raw), .y_min_i(cfg_y_min), .y_max_i(cfg_y_max), .awu_i(cfg_awu_en),
        .cand_i(cand), .base_i(base), .y_o(y_next), .accept_o(accept)
    );

    // State update: output, readback and integrator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            rb_integ  <= '0;
            rb_last_x <= '0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) begin
                out_word  <= y_next;
                rb_last_x <= smp_err;
                rb_integ  <= accept ? cand : base;
            end else if (integ_clr) begin
                rb_integ  <= '0;
            end
        end
    end

    // Strobe latency: output strobe follows each sample strobe.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);
    // Output never leaves the window it was computed against.
    p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_y_min) <= $past(cfg_y_max)) |->
        (out_word >= $past(cfg_y_min) && out_word <= $past(cfg_y_max)));
    // Readback holds between samples.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(out_word) && $stable(rb_last_x)));
    // A lone clear zeroes the integrator.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_clr && !smp_valid) |=> (rb_integ == '0));
    // Integrator only moves on a sample or a clear.
    p_integ_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!integ_clr && !smp_valid) |=> $stable(rb_integ));
endmodule

// File: tb/pi_regulator_bench.sv
module pi_regulator_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_err = '0;
    logic signed [15:0] cfg_kp = '0, cfg_ki = '0, cfg_bias = '0;
    logic signed [15:0] cfg_y_min = -16'sd32768, cfg_y_max = 16'sd32767;
    logic               cfg_awu_en = 1'b0;
    logic               integ_clr = 1'b0;
    logic               out_valid;
    logic signed [15:0] out_word;
    logic signed [31:0] rb_integ;
    logic signed [15:0] rb_last_x;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    longint m_integ = 0;

    always #5 clk = ~clk;

    pi_regulator u_pi_regulator (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_err(smp_err),
        .cfg_kp(cfg_kp), .cfg_ki(cfg_ki), .cfg_bias(cfg_bias),
        .cfg_y_min(cfg_y_min), .cfg_y_max(cfg_y_max), .cfg_awu_en(cfg_awu_en),
        .integ_clr(integ_clr), .out_valid(out_valid), .out_word(out_word),
        .rb_integ(rb_integ), .rb_last_x(rb_last_x)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int kp, input int ki, input int bias,
                           input int ymin, input int ymax, input bit awu);
        @(negedge clk);
        cfg_kp = 16'(kp); cfg_ki = 16'(ki); cfg_bias = 16'(bias);
        cfg_y_min = 16'(ymin); cfg_y_max = 16'(ymax); cfg_awu_en = awu;
    endtask

    // Applies one sample, checks output, integrator and readback one cycle later.
    task automatic apply(input int x, input bit clr, input string req);
        longint base, cand, acc, u, y, lo, hi;
        bit acc_ok;
        base = clr ? 0 : m_integ;
        cand = base + x;
        acc  = cand * longint'(cfg_ki) + longint'(x) * longint'(cfg_kp);
        u    = (acc >>> 12) + longint'(cfg_bias);
        lo = cfg_y_min; hi = cfg_y_max;
        if (u < lo)      begin y = lo; acc_ok = !cfg_awu_en || (cand > base); end
        else if (u > hi) begin y = hi; acc_ok = !cfg_awu_en || (cand < base); end
        else             begin y = u;  acc_ok = 1; end
        m_integ = acc_ok ? cand : base;
        @(negedge clk);
        smp_valid = 1'b1; smp_err = 16'(x); integ_clr = clr;
        @(negedge clk);
        smp_valid = 1'b0; integ_clr = 1'b0;
        chk(out_valid == 1'b1, "R2 valid", longint'(out_valid), 1);
        chk(longint'(out_word) == y, {req, " out"}, out_word, y);
        chk(longint'(rb_integ) == m_integ, {req, " integ"}, rb_integ, m_integ);
        chk(longint'(rb_last_x) == x, "R11 last_x", rb_last_x, x);
    endtask

    task automatic t_reset();
        chk(out_valid == 0, "R1 valid", out_valid, 0);
        chk(out_word == 0, "R1 out", out_word, 0);
        chk(rb_integ == 0, "R1 integ", rb_integ, 0);
        chk(rb_last_x == 0, "R1 last_x", rb_last_x, 0);
    endtask

    task automatic t_proportional();
        set_cfg(4096, 0, 0, -32768, 32767, 0);
        apply(100, 0, "R3 unity kp");
        apply(-7, 0, "R3 unity kp neg");
        set_cfg(2048, 0, 0, -32768, 32767, 0);
        apply(-3, 0, "R3 floor shift");
        chk(out_word == -2, "R3 floor literal", out_word, -2);
    endtask

    task automatic t_integral();
        apply(0, 1, "R10 restart");
        set_cfg(0, 4096, 10, -32768, 32767, 0);
        apply(5, 0, "R6 integrate");
        apply(5, 0, "R6 integrate");
        apply(-3, 0, "R6 integrate");
        chk(out_word == 17, "R3 integral literal", out_word, 17);
    endtask

    task automatic t_clear_idle();
        logic signed [15:0] y0, x0;
        y0 = out_word; x0 = rb_last_x;
        @(negedge clk); integ_clr = 1'b1;
        @(negedge clk); integ_clr = 1'b0;
        m_integ = 0;
        chk(rb_integ == 0, "R9 clear", rb_integ, 0);
        chk(out_word == y0, "R9 out kept", out_word, y0);
        chk(rb_last_x == x0, "R9 last_x kept", rb_last_x, x0);
        chk(out_valid == 0, "R2 no strobe", out_valid, 0);
        apply(4, 0, "R9 gains kept");
        chk(out_word == 14, "R9 bias kept", out_word, 14);
    endtask

    task automatic t_clamp_plain();
        set_cfg(0, 4096, 0, -100, 100, 0);
        apply(80, 0, "R6 in range");
        apply(80, 0, "R5 high clamp no awu");
        chk(rb_integ == 164, "R6 integ runs on", rb_integ, 164);
        apply(-400, 0, "R4 low clamp no awu");
    endtask

    task automatic t_awu();
        apply(0, 1, "R10 restart");
        set_cfg(0, 4096, 0, -100, 100, 1);
        apply(80, 0, "R6 in range");
        apply(80, 0, "R8 freeze high");
        chk(rb_integ == 80, "R8 frozen literal", rb_integ, 80);
        chk(out_word == 100, "R5 max literal", out_word, 100);
        set_cfg(0, 4096, 300, -100, 100, 1);
        apply(-5, 0, "R8 accept toward window");
        chk(rb_integ == 75, "R8 accept literal", rb_integ, 75);
        set_cfg(0, 4096, 0, -100, 100, 1);
        apply(-155, 0, "R6 in range");
        apply(-50, 0, "R7 freeze low");
        chk(rb_integ == -80, "R7 frozen literal", rb_integ, -80);
        chk(out_word == -100, "R4 min literal", out_word, -100);
        set_cfg(0, 4096, -200, -100, 100, 1);
        apply(5, 0, "R7 accept toward window");
        chk(rb_integ == -75, "R7 accept literal", rb_integ, -75);
    endtask

    task automatic t_clear_collide();
        set_cfg(4096, 4096, 0, -32768, 32767, 0);
        apply(50, 0, "R6 build");
        apply(7, 1, "R10 clear with sample");
        chk(rb_integ == 7, "R10 integ literal", rb_integ, 7);
        chk(out_word == 14, "R10 out literal", out_word, 14);
    endtask

    task automatic t_gaps();
        logic signed [15:0] y0;
        apply(3, 0, "R11 sample");
        y0 = out_word;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 0, "R2 idle", out_valid, 0);
            chk(out_word == y0, "R11 hold", out_word, y0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_proportional();
        t_integral();
        t_clear_idle();
        t_clamp_plain();
        t_awu();
        t_clear_collide();
        t_gaps();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule